// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Logic

This block tracks the interrupt requests of one UART channel and reports which one the host should service first. Status from the receive FIFO, the transmit FIFO, the line error logic, the modem change logic and the character timeout timer arrives as plain inputs. Event-type sources are held in pending flags. The receive-level source follows the FIFO fill level directly. Every source passes through its own enable bit before a fixed-priority encoder. The encoder yields a 4-bit identification code and drives an active-high interrupt request.

Each pending flag is cleared by the host access that services it. The host bus supplies one-cycle strobes for reads of the line status, receive holding, modem status and identification registers, and for writes to the transmit holding register. Only the most urgent enabled source is shown at a time. The others stay pending and appear in turn as the higher ones are cleared.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset `ident` is 6'b000001, `irq` is 0 and no flag is pending.
- R2: `ident[0]` is 0 exactly when some enabled source is pending, `irq` is the inverse of `ident[0]`, and `ident[5:4]` always reads 0.
- R3: Priority, highest first, with `ident[3:0]` codes: line error 4'b0110, receive timeout 4'b1100, receive level 4'b0100, transmit empty 4'b0010, modem change 4'b0000, none 4'b0001. A lower source appears once every higher one is cleared or disabled.
- R4: A cycle with any bit of `lsr_err` high sets the line-error flag. It stays set until a cycle with `rd_lsr` high, and clears at that clock edge.
- R5: A cycle with `rx_tout` high sets the timeout flag. A cycle with `rd_rhr` high clears it.
- R6: The receive-level source is active while `rx_level >= rx_trig`, with no memory. It drops in the cycle the level goes below the trigger.
- R7: A 0-to-1 change of `tx_empty` sets the transmit flag (reset treats the FIFO as already empty). A cycle with `wr_thr` high clears it.
- R8: A cycle with `rd_iir` high clears the transmit flag only if `ident[3:0]` is 4'b0010 in that cycle. Otherwise the flag stays pending.
- R9: A cycle with any bit of `msr_delta` high sets the modem flag. A cycle with `rd_msr` high clears it.
- R10: `ien` bit 0 enables line error, bit 1 timeout, bit 2 receive level, bit 3 transmit, bit 4 modem. A disabled source never reaches `ident` or `irq`, but its flag is kept and shows once the bit is set.
- R11: When a set event and a clear strobe for the same flag fall in one cycle, the flag ends that cycle set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lsr_err | input | 4 | Line error events: overrun, parity, framing, break |
| rx_tout | input | 1 | Character timeout expired (one-cycle pulse) |
| rx_level | input | 5 | Receive FIFO fill level |
| rx_trig | input | 5 | Receive trigger level |
| tx_empty | input | 1 | Transmit FIFO empty (level) |
| msr_delta | input | 4 | Modem change events |
| ien | input | 5 | Per-source enable bits |
| rd_iir | input | 1 | Identification register read strobe |
| rd_lsr | input | 1 | Line status register read strobe |
| rd_rhr | input | 1 | Receive holding register read strobe |
| rd_msr | input | 1 | Modem status register read strobe |
| wr_thr | input | 1 | Transmit holding register write strobe |
| ident | output | 6 | Identification code; bits 5:4 zero |
| irq | output | 1 | Interrupt request, active high |

## Verification
The two functions that collide are setting a flag and clearing it by a bus access in the same cycle. One case is a line error arriving on the cycle the line status register is read. The other is a fresh transmit-empty edge arriving on the cycle an identification read returns the transmit code. The bench drives both events together between two clock edges. It expects the flag still to be shown afterwards, and it expects a later clear strobe with no event to remove the flag.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   localparam int NSRC = 5;

   // source index doubles as priority rank: 0 is most urgent
   localparam int SRC_LINE  = 0;
   localparam int SRC_TOUT  = 1;
   localparam int SRC_RXLVL = 2;
   localparam int SRC_TX    = 3;
   localparam int SRC_MODEM = 4;

   localparam logic [3:0] CODE_LINE  = 4'b0110;
   localparam logic [3:0] CODE_TOUT  = 4'b1100;
   localparam logic [3:0] CODE_RXLVL = 4'b0100;
   localparam logic [3:0] CODE_TX    = 4'b0010;
   localparam logic [3:0] CODE_MODEM = 4'b0000;
   localparam logic [3:0] CODE_NONE  = 4'b0001;

   function automatic logic [3:0] src_code(input int idx);
      case (idx)
         SRC_LINE:  return CODE_LINE;
         SRC_TOUT:  return CODE_TOUT;
         SRC_RXLVL: return CODE_RXLVL;
         SRC_TX:    return CODE_TX;
         default:   return CODE_MODEM;
      endcase
   endfunction
endpackage

// File: rtl/uart_irq_flag.sv
// Pending flag: set dominates clear.
module uart_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end
endmodule

// File: rtl/uart_irq_rise.sv
// Rising-edge detector with a chosen idle value after reset.
module uart_irq_rise #(
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   logic din_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) din_q <= RST_VAL;
      else        din_q <= din;
   end
   assign rise = din & ~din_q;
endmodule

// File: rtl/uart_irq_prio.sv
// Fixed-priority encoder: index 0 wins.
module uart_irq_prio
   import uart_irq_pkg::*;
#(
   parameter int N = NSRC
) (
   input  logic [N-1:0] req,
   output logic [3:0]   code,
   output logic [N-1:0] grant
);
   if (N < 1 || N > NSRC) begin : g_bad_n
      $error("uart_irq_prio: N out of range");
   end

   always_comb begin
      code  = CODE_NONE;
      grant = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            code     = src_code(i);
            grant    = '0;
            grant[i] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
   import uart_irq_pkg::*;
#(
   parameter int FIFO_DEPTH = 16,
   parameter int LSR_FLAGS  = 4,
   parameter int MSR_FLAGS  = 4,
   localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [LSR_FLAGS-1:0] lsr_err,
   input  logic                 rx_tout,
   input  logic [LVL_W-1:0]     rx_level,
   input  logic [LVL_W-1:0]     rx_trig,
   input  logic                 tx_empty,
   input  logic [MSR_FLAGS-1:0] msr_delta,
   input  logic [NSRC-1:0]      ien,
   input  logic                 rd_iir,
   input  logic                 rd_lsr,
   input  logic                 rd_rhr,
   input  logic                 rd_msr,
   input  logic                 wr_thr,
   output logic [5:0]           ident,
   output logic                 irq
);
   if (FIFO_DEPTH < 1) begin : g_bad_depth
      $error("uart_irq_ident: FIFO_DEPTH must be at least 1");
   end
   if (LSR_FLAGS < 1 || MSR_FLAGS < 1) begin : g_bad_flags
      $error("uart_irq_ident: flag widths must be at least 1");
   end

   logic            tx_rise;
   logic [NSRC-1:0] set_v, clr_v, raw, req, grant;
   logic [3:0]      code;

   uart_irq_rise #(.RST_VAL(1'b1)) u_tx_edge (
      .clk (clk), .rst_n (rst_n), .din (tx_empty), .rise (tx_rise)
   );

   always_comb begin
      set_v            = '0;
      clr_v            = '0;
      set_v[SRC_LINE]  = |lsr_err;
      clr_v[SRC_LINE]  = rd_lsr;
      set_v[SRC_TOUT]  = rx_tout;
      clr_v[SRC_TOUT]  = rd_rhr;
      set_v[SRC_TX]    = tx_rise;
      clr_v[SRC_TX]    = wr_thr | (rd_iir & grant[SRC_TX]);
      set_v[SRC_MODEM] = |msr_delta;
      clr_v[SRC_MODEM] = rd_msr;
   end

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      if (i == SRC_RXLVL) begin : g_level
         assign raw[i] = (rx_level >= rx_trig);
      end else begin : g_latch
         uart_irq_flag u_flag (
            .clk (clk), .rst_n (rst_n),
            .set (set_v[i]), .clr (clr_v[i]), .q (raw[i])
         );
      end
   end

   assign req = raw & ien;

   uart_irq_prio #(.N(NSRC)) u_prio (
      .req (req), .code (code), .grant (grant)
   );

   assign ident = {2'b00, code};
   assign irq   = ~code[0];
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
   parameter int LVL_W = 5,
   parameter int LSR_FLAGS = 4,
   parameter int MSR_FLAGS = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [LSR_FLAGS-1:0] lsr_err,
   input logic                 rx_tout,
   input logic [LVL_W-1:0]     rx_level,
   input logic [LVL_W-1:0]     rx_trig,
   input logic                 tx_empty,
   input logic [MSR_FLAGS-1:0] msr_delta,
   input logic [4:0]           ien,
   input logic                 rd_iir,
   input logic                 rd_lsr,
   input logic                 rd_rhr,
   input logic                 rd_msr,
   input logic                 wr_thr,
   input logic [5:0]           ident,
   input logic                 irq
);
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) ident[5:4] == 2'b00); // R2
   AST_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n) (ien == '0) |-> (!irq && ident == 6'b000001)); // R10
   AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (ident[3:0] == 4'b0110 && !rd_lsr) |=> (!ien[0] || ident[3:0] == 4'b0110)); // R4
   AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (rd_lsr && lsr_err == '0) |=> ident[3:0] != 4'b0110); // R4
   AST_TOUT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (rd_rhr && !rx_tout) |=> ident[3:0] != 4'b1100); // R5
   AST_LEVEL_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (ident[3:0] == 4'b0100) |-> (ien[2] && rx_level >= rx_trig)); // R6
   AST_TX_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (rd_iir && ident[3:0] == 4'b0010 && !$rose(tx_empty)) |=> ident[3:0] != 4'b0010); // R8
   AST_MODEM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (rd_msr && msr_delta == '0) |=> ident[3:0] != 4'b0000); // R9
endmodule

bind uart_irq_ident uart_irq_ident_chk #(
   .LVL_W(LVL_W), .LSR_FLAGS(LSR_FLAGS), .MSR_FLAGS(MSR_FLAGS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .lsr_err(lsr_err), .rx_tout(rx_tout),
   .rx_level(rx_level), .rx_trig(rx_trig), .tx_empty(tx_empty),
   .msr_delta(msr_delta), .ien(ien), .rd_iir(rd_iir), .rd_lsr(rd_lsr),
   .rd_rhr(rd_rhr), .rd_msr(rd_msr), .wr_thr(wr_thr),
   .ident(ident), .irq(irq)
);

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] lsr_err = '0;
   logic       rx_tout = 1'b0;
   logic [4:0] rx_level = '0;
   logic [4:0] rx_trig = 5'd4;
   logic       tx_empty = 1'b1;
   logic [3:0] msr_delta = '0;
   logic [4:0] ien = 5'h1f;
   logic       rd_iir = 1'b0, rd_lsr = 1'b0, rd_rhr = 1'b0, rd_msr = 1'b0, wr_thr = 1'b0;
   logic [5:0] ident;
   logic       irq;
   int         n_chk = 0, n_fail = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   uart_irq_ident u0 (
      .clk(clk), .rst_n(rst_n), .lsr_err(lsr_err), .rx_tout(rx_tout),
      .rx_level(rx_level), .rx_trig(rx_trig), .tx_empty(tx_empty),
      .msr_delta(msr_delta), .ien(ien), .rd_iir(rd_iir), .rd_lsr(rd_lsr),
      .rd_rhr(rd_rhr), .rd_msr(rd_msr), .wr_thr(wr_thr),
      .ident(ident), .irq(irq)
   );

   task automatic chk(input string tag, input logic [5:0] exp);
      n_chk++;
      if (ident !== exp || irq !== ~exp[0]) begin
         n_fail++;
         $display("FAIL %s ident=%b irq=%b expected ident=%b irq=%b", tag, ident, irq, exp, ~exp[0]);
      end
   endtask

   // one clock edge passes; inputs driven beforehand are then cleared
   task automatic step();
      @(negedge clk);
      lsr_err = '0; rx_tout = 0; msr_delta = '0;
      rd_iir = 0; rd_lsr = 0; rd_rhr = 0; rd_msr = 0; wr_thr = 0;
      #0.5;
   endtask

   task automatic raise_tx();
      tx_empty = 0; step();
      tx_empty = 1; step();
   endtask

   task automatic t_reset();
      chk("R1 reset", 6'b000001);
   endtask

   task automatic t_line();
      lsr_err = 4'b0100; step();
      chk("R4 line set", 6'b000110);
      step(); step();
      chk("R4 line held", 6'b000110);
      rd_iir = 1; step();
      chk("R4 iir read keeps line", 6'b000110);
      rd_lsr = 1; step();
      chk("R4 line cleared", 6'b000001);
   endtask

   task automatic t_timeout();
      rx_tout = 1; step();
      chk("R5 timeout set", 6'b001100);
      rd_rhr = 1; step();
      chk("R5 timeout cleared", 6'b000001);
   endtask

   task automatic t_rxlvl();
      rx_level = 5'd3; #0.5;
      chk("R6 below trigger", 6'b000001);
      rx_level = 5'd4; #0.5;
      chk("R6 at trigger", 6'b000100);
      rd_iir = 1; step();
      chk("R6 iir read keeps level", 6'b000100);
      rx_level = 5'd3; #0.5;
      chk("R6 dropped", 6'b000001);
   endtask

   task automatic t_tx();
      raise_tx();
      chk("R7 tx set on empty edge", 6'b000010);
      wr_thr = 1; step();
      chk("R7 tx cleared by write", 6'b000001);
      raise_tx();
      rd_iir = 1; step();
      chk("R8 tx cleared by iir read", 6'b000001);
   endtask

   task automatic t_tx_behind();
      raise_tx();
      rx_tout = 1; step();
      chk("R3 timeout above tx", 6'b001100);
      rd_iir = 1; step();
      chk("R8 read of higher code", 6'b001100);
      rd_rhr = 1; step();
      chk("R8 tx still queued", 6'b000010);
      rd_iir = 1; step();
      chk("R8 tx then cleared", 6'b000001);
   endtask

   task automatic t_modem();
      msr_delta = 4'b0001; step();
      chk("R9 modem set", 6'b000000);
      rd_msr = 1; step();
      chk("R9 modem cleared", 6'b000001);
   endtask

   task automatic t_priority();
      tx_empty = 0; step();
      lsr_err = 4'b1000; rx_tout = 1; rx_level = 5'd6; tx_empty = 1; msr_delta = 4'b1000;
      step();
      chk("R3 line first", 6'b000110);
      rd_lsr = 1; step();
      chk("R3 timeout second", 6'b001100);
      rd_rhr = 1; step();
      chk("R3 level third", 6'b000100);
      rx_level = 5'd2; #0.5;
      chk("R3 tx fourth", 6'b000010);
      wr_thr = 1; step();
      chk("R3 modem fifth", 6'b000000);
      rd_msr = 1; step();
      chk("R2 idle again", 6'b000001);
   endtask

   task automatic t_mask();
      ien = 5'h00;
      lsr_err = 4'b0010; step();
      chk("R10 masked line", 6'b000001);
      ien = 5'h1f; #0.5;
      chk("R10 enable reveals line", 6'b000110);
      ien = 5'h1e; msr_delta = 4'b0100; step();
      chk("R10 line masked modem shown", 6'b000000);
      rd_lsr = 1; rd_msr = 1; step();
      ien = 5'h1f; #0.5;
      chk("R10 both cleared", 6'b000001);
   endtask

   task automatic t_same();
      lsr_err = 4'b0001; rd_lsr = 1; step();
      chk("R11 line set wins", 6'b000110);
      rd_lsr = 1; step();
      chk("R11 line later cleared", 6'b000001);
      raise_tx();
      tx_empty = 0; step();
      chk("R11 tx pending", 6'b000010);
      tx_empty = 1; rd_iir = 1; step();
      chk("R11 tx set wins over read", 6'b000010);
      wr_thr = 1; step();
      chk("R11 tx later cleared", 6'b000001);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #0.5;
      t_reset();
      rst_n = 1;
      step();
      t_reset();
      t_line();
      t_timeout();
      t_rxlvl();
      t_tx();
      t_tx_behind();
      t_modem();
      t_priority();
      t_mask();
      t_same();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog (R1..R11 run) actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule